// File: doc/BRIEF.md
# Self-Initializing Page Segment Register File

This block holds the four segment registers of a Z80-style memory mapper, one per 16 KB page of the CPU address space. Each register names the physical 16 KB segment that backs its page. The upper two CPU memory address bits choose one register, and its value is driven out combinationally as the segment number for the current access.

Software does not need to set up the registers before the mapper can be used. When reset is released, a small sequencer takes over the register write port for four clock cycles. In each cycle it writes the entry index into that entry, so page n starts out mapped to segment n. After the fourth write the sequencer sets its done state and freezes. From then on the write port belongs to CPU I/O writes on ports 0xFC to 0xFF.

Reads of those ports return the stored segment numbers. While such a read is in progress, a bus-direction flag is raised so that an external buffer can drive the data bus.

Top module: `page_mapper`

## Requirements
- R1: Four clock edges after reset is released, entry n holds segment n for every n in 0..3. No CPU access is needed for this.
- R2: `seg_o` always equals the entry selected by `mem_page_i` (A15:A14), with no clock delay.
- R3: Once initialisation is complete, an I/O write to port 0xFC+n stores bits 4:0 of the write data into entry n on the next clock edge. Data bits 7:5 are discarded.
- R4: An I/O write to a mapper port during the four initialisation cycles has no effect on any entry.
- R5: An I/O read of port 0xFC+n returns entry n in bits 4:0 of `io_rdata_o`, with bits 7:5 set to 1.
- R6: `bus_dir_o` is 1 exactly when `io_rd_i` is high and `io_addr_i` lies in 0xFC..0xFF.
- R7: Writes to ports outside 0xFC..0xFF leave all entries unchanged. `io_rdata_o` is 0 whenever no mapper port is being read.
- R8: Asserting `rst_ni` low clears all entries to 0 and restarts the initialisation sequence, which again yields the identity layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 8 | CPU I/O port address |
| io_wr_i | input | 1 | CPU I/O write strobe |
| io_rd_i | input | 1 | CPU I/O read strobe |
| io_wdata_i | input | 8 | CPU I/O write data |
| io_rdata_o | output | 8 | Readback data |
| bus_dir_o | output | 1 | High while a mapper port is read |
| mem_page_i | input | 2 | CPU memory address bits A15:A14 |
| seg_o | output | 5 | Segment number for the selected page |

## Verification
The hardest case to reach is a CPU write that arrives while the sequencer still owns the write port. The bench issues a write to port 0xFE with all data bits set in the very first cycle after reset is released. It then reads the ports during the remaining initialisation cycles and confirms after completion that entry 2 still holds 2. A second reset in the middle of the run, issued after every entry has been overwritten, shows that the identity layout is rebuilt.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned PAGES   = 4;
  localparam int unsigned IDX_W   = $clog2(PAGES);
  localparam int unsigned SEG_W   = 5;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IOA_W   = 8;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/mapper_init_seq.sv
module mapper_init_seq
  import mapper_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic we_o,
  output idx_t idx_o,
  output logic done_o
);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] cnt_q;

  // counter stops once it reaches PAGES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_W'(PAGES));
  assign we_o   = !done_o;
  assign idx_o  = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/mapper_port_decode.sv
module mapper_port_decode
  import mapper_pkg::*;
#(
  parameter logic [IOA_W-1:0] PORT_BASE = 8'hFC
) (
  input  logic [IOA_W-1:0] addr_i,
  output logic             hit_o,
  output idx_t             idx_o
);
  assign hit_o = (addr_i[IOA_W-1:IDX_W] == PORT_BASE[IOA_W-1:IDX_W]);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  idx_t widx_i,
  input  seg_t wdata_i,
  input  idx_t ridx_a_i,
  output seg_t rdata_a_o,
  input  idx_t ridx_b_i,
  output seg_t rdata_b_o
);
  seg_t ent_q [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (we_i && widx_i == idx_t'(g)) ent_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = ent_q[ridx_a_i];
  assign rdata_b_o = ent_q[ridx_b_i];
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter logic [7:0] PORT_BASE = 8'hFC
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] io_addr_i,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  output logic       bus_dir_o,
  input  logic [1:0] mem_page_i,
  output logic [4:0] seg_o
);
  logic init_we, init_done, port_hit;
  idx_t init_idx, port_idx, widx;
  logic we;
  seg_t wdata, rb_seg;

  mapper_init_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_o   (init_we),
    .idx_o  (init_idx),
    .done_o (init_done)
  );

  mapper_port_decode #(.PORT_BASE(PORT_BASE)) u_dec (
    .addr_i (io_addr_i),
    .hit_o  (port_hit),
    .idx_o  (port_idx)
  );

  // sequencer owns the write port until done
  always_comb begin
    if (init_done) begin
      we    = io_wr_i && port_hit;
      widx  = port_idx;
      wdata = io_wdata_i[SEG_W-1:0];
    end else begin
      we    = init_we;
      widx  = init_idx;
      wdata = seg_t'(init_idx);
    end
  end

  mapper_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .widx_i    (widx),
    .wdata_i   (wdata),
    .ridx_a_i  (mem_page_i),
    .rdata_a_o (seg_o),
    .ridx_b_i  (port_idx),
    .rdata_b_o (rb_seg)
  );

  assign bus_dir_o  = io_rd_i && port_hit;
  assign io_rdata_o = bus_dir_o ? {{(DATA_W-SEG_W){1'b1}}, rb_seg} : '0;
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk
  import mapper_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] io_addr_i,
  input logic       io_wr_i,
  input logic       io_rd_i,
  input logic [7:0] io_wdata_i,
  input logic [7:0] io_rdata_o,
  input logic       bus_dir_o,
  input logic [1:0] mem_page_i,
  input logic [4:0] seg_o,
  input logic       init_done,
  input logic       port_hit,
  input idx_t       port_idx,
  input seg_t       rb_seg
);
  // R1
  identity_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done) |-> (rb_seg == seg_t'(port_idx)));

  // R1
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done |=> init_done);

  // R3
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done && io_wr_i && port_hit && mem_page_i == port_idx)
      |=> (seg_o == $past(io_wdata_i[SEG_W-1:0]) || !$stable(mem_page_i)));

  // R5
  rdata_top_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dir_o |-> (io_rdata_o[7:5] == 3'b111));

  // R6
  dir_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dir_o |-> (io_rd_i && port_hit));

  // R7
  rdata_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_dir_o |-> (io_rdata_o == '0));
endmodule

bind page_mapper page_mapper_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .bus_dir_o  (bus_dir_o),
  .mem_page_i (mem_page_i),
  .seg_o      (seg_o),
  .init_done  (init_done),
  .port_hit   (port_hit),
  .port_idx   (port_idx),
  .rb_seg     (rb_seg)
);

// File: tb/tb_page_mapper.sv
`timescale 1ns/1ps
module tb_page_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] page = '0;
  logic [7:0] rdata;
  logic       dir;
  logic [4:0] seg;

  int total = 0;
  int bad = 0;
  int m_seg [4];
  int m_cnt;

  always #5 clk = ~clk;

  page_mapper dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr),
    .io_rd_i(rd), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .bus_dir_o(dir), .mem_page_i(page), .seg_o(seg)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_seg[i] = 0;
    end else if (m_cnt < 4) begin
      m_seg[m_cnt] = m_cnt;
      m_cnt++;
    end else if (wr && addr >= 8'hFC) begin
      m_seg[addr - 8'hFC] = wdata & 8'h1F;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic w, input logic r,
                      input logic [7:0] a, input logic [7:0] d, input logic [1:0] p);
    int exp_rd;
    int exp_dir;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; page = p;
    #1;
    exp_dir = (r && a >= 8'hFC) ? 1 : 0;
    exp_rd  = exp_dir ? (8'hE0 | m_seg[a - 8'hFC]) : 0;
    chk({req, " seg"}, seg, m_seg[p]);
    chk({req, " rdata"}, rdata, exp_rd);
    chk({req, " dir"}, dir, exp_dir);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 0; rd = 0;
    #1;
    chk("R8 reset seg", seg, 0);
    chk("R7 reset rdata", rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R4: write while the sequencer still owns the port
    step("R4", 1, 0, 8'hFE, 8'hFF, 2'd2);
    step("R4", 0, 1, 8'hFC, 8'h00, 2'd0);
    step("R4", 1, 1, 8'hFD, 8'h1F, 2'd1);
    step("R4", 0, 1, 8'hFF, 8'h00, 2'd3);
    // R1/R5/R2 identity layout
    for (int i = 0; i < 4; i++) begin
      step("R1", 0, 1, 8'hFC + 8'(i), 8'h00, 2'(i));
      chk("R1 identity", seg, i);
    end
    for (int i = 0; i < 4; i++) step("R5", 0, 1, 8'hFC + 8'(i), 8'h00, 2'(3 - i));
    // R3 writes with high bits set
    step("R3", 1, 0, 8'hFC, 8'hE7, 2'd0);
    step("R3", 1, 0, 8'hFD, 8'h1A, 2'd0);
    step("R3", 1, 0, 8'hFE, 8'h55, 2'd1);
    step("R3", 1, 0, 8'hFF, 8'hF3, 2'd2);
    for (int i = 0; i < 4; i++) step("R3", 0, 1, 8'hFC + 8'(i), 8'h00, 2'(i));
    chk("R3 masked", seg, 5'h13);
    // R2 page sweep
    for (int i = 0; i < 4; i++) step("R2", 0, 0, 8'h00, 8'h00, 2'(i));
    // R7 foreign ports
    step("R7", 1, 0, 8'hFB, 8'h0F, 2'd0);
    step("R7", 1, 0, 8'h7C, 8'h0F, 2'd0);
    step("R7", 1, 0, 8'h00, 8'h0F, 2'd0);
    step("R6", 0, 1, 8'hFB, 8'h00, 2'd0);
    step("R6", 0, 1, 8'h7D, 8'h00, 2'd1);
    step("R6", 0, 0, 8'hFD, 8'h00, 2'd1);
    step("R7", 0, 1, 8'hFC, 8'h00, 2'd0);
    chk("R7 untouched", seg, 7);
    // R8 restart
    do_reset();
    for (int i = 0; i < 4; i++) step("R8", 0, 0, 8'h00, 8'h00, 2'd0);
    for (int i = 0; i < 4; i++) begin
      step("R8", 0, 1, 8'hFC + 8'(i), 8'h00, 2'(i));
      chk("R8 identity", seg, i);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule